// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two multi-digit base-3 numbers and a carry-in digit, and returns a sum of the same width plus a carry-out digit. Each base-3 digit (trit) travels on a pair of binary wires, so the adder fits into ordinary binary logic. A chain of identical digit cells does the work. Each cell turns its three incoming trits into one-hot lines, forms the digit total as a small binary integer, splits that total into a result digit and a carry, and turns both back into two-bit trit codes. The carry of digit i is the carry-in of digit i+1.

A mode input picks how the codes are read. In unsigned mode the digits are 0, 1 and 2. In signed-digit (balanced) mode the digits are -1, 0 and +1, and no sign digit is needed. In signed-digit mode a second input negates operand B digit by digit, so the same hardware subtracts. A code that stands for no digit raises an error flag. The block is purely combinational. The digit count is a parameter that defaults to four.

Top module: `ternary_rc_adder`

## Requirements
- R1: Trit codes: 2'b00 is digit 0 and 2'b01 is digit 1. 2'b10 is digit 2 in unsigned mode (`bal_mode`=0) and digit -1 in balanced mode (`bal_mode`=1). Digit i of a bus sits in bits [2i+1:2i].
- R2: Unsigned mode, for every one of the 27 combinations of A digit, B digit and carry-in: the lowest sum digit equals the total mod 3, and the next digit (whose operand digits are zero) equals the total div 3.
- R3: Unsigned mode with legal codes: value(sum) + 3^N * value(carry_out) equals value(A) + value(B) + value(carry_in).
- R4: Unsigned mode with legal codes and carry_in equal to 0 or 1: carry_out is never digit 2.
- R5: Balanced mode, for every one of the 27 combinations: the lowest sum digit d and the next digit c satisfy d + 3c = a + b + cin, with d and c in {-1, 0, +1}.
- R6: Balanced mode with legal codes: value(sum) + 3^N * value(carry_out) equals value(A) + value(B) + value(carry_in).
- R7: Balanced mode with `negate_b`=1 swaps codes 01 and 10 in every B digit, so the result equals A - B + carry_in.
- R8: `negate_b` has no effect in unsigned mode.
- R9: Code 2'b11 on any digit of A, B or carry_in sets `code_err`. That digit is then taken as 0. With legal codes `code_err` is 0.
- R10: With legal inputs, no output digit carries code 2'b11.
- R11: A balanced single-digit add with zero carry-in gives a nonzero carry for exactly two of the nine digit pairs: (+1,+1) and (-1,-1).
- R12: All-zero inputs give an all-zero sum, a zero carry-out and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bal_mode | input | 1 | 1 selects balanced digits {-1,0,+1}, 0 selects unsigned digits {0,1,2} |
| negate_b | input | 1 | In balanced mode, negates operand B digit by digit |
| op_a | input | 2N | Operand A, N trit codes, digit 0 in the low bits |
| op_b | input | 2N | Operand B, N trit codes |
| carry_in | input | 2 | Carry-in trit code into digit 0 |
| sum | output | 2N | Sum, N trit codes |
| carry_out | output | 2 | Carry-out trit code from the top digit |
| code_err | output | 1 | An input digit carries the unused code 2'b11 |

## Verification
The hardest case to reach is a carry that ripples across every digit. In unsigned mode this needs all digits at their maximum plus a carry-in. In balanced mode it needs a run of +1 digits or a run of -1 digits that pushes the total past the symmetric range. The stimulus builds these extremes by hand and adds a pseudo-random sweep over the full operand ranges in both modes. The carry leaving a single cell is observed through the next sum digit: the second digits of A and B are held at zero, so that digit shows the carry directly in all 27 combinations.

// File: rtl/tadd_pkg.sv
package tadd_pkg;
  typedef logic [1:0] trit_code_t;

  localparam trit_code_t TC_ZERO = 2'b00;
  localparam trit_code_t TC_ONE  = 2'b01;
  localparam trit_code_t TC_HIGH = 2'b10;  // 2 unsigned, -1 balanced
  localparam trit_code_t TC_BAD  = 2'b11;

  localparam int unsigned OH_W = 3;
  typedef logic [OH_W-1:0] trit_oh_t;  // [0]=zero [1]=one [2]=high

  typedef logic signed [3:0] dsum_t;

  function automatic trit_oh_t val_to_oh(input dsum_t v);
    trit_oh_t oh;
    oh = '0;
    if (v == 4'sd0)      oh[0] = 1'b1;
    else if (v == 4'sd1) oh[1] = 1'b1;
    else                 oh[2] = 1'b1;  // 2 or -1
    return oh;
  endfunction
endpackage

// File: rtl/trit_decoder.sv
module trit_decoder
  import tadd_pkg::*;
(
  input  trit_code_t code_i,
  output trit_oh_t   oh_o,
  output logic       bad_o
);
  always_comb begin
    bad_o   = (code_i == TC_BAD);
    oh_o[0] = (code_i == TC_ZERO) || bad_o;
    oh_o[1] = (code_i == TC_ONE);
    oh_o[2] = (code_i == TC_HIGH);
  end
endmodule

// File: rtl/trit_encoder.sv
module trit_encoder
  import tadd_pkg::*;
(
  input  trit_oh_t   oh_i,
  output trit_code_t code_o
);
  always_comb begin
    code_o = TC_ZERO;
    if (oh_i[1]) code_o = TC_ONE;
    if (oh_i[2]) code_o = TC_HIGH;
  end
endmodule

// File: rtl/trit_digit_cell.sv
module trit_digit_cell
  import tadd_pkg::*;
(
  input  logic       bal_i,
  input  trit_code_t a_i,
  input  trit_code_t b_i,
  input  trit_code_t c_i,
  output trit_code_t s_o,
  output trit_code_t c_o,
  output logic       err_o
);
  localparam int unsigned NIN = 3;

  trit_code_t codes [NIN];
  trit_oh_t   ohs   [NIN];
  logic [NIN-1:0] bads;
  dsum_t      vals  [NIN];

  assign codes[0] = a_i;
  assign codes[1] = b_i;
  assign codes[2] = c_i;

  for (genvar g = 0; g < NIN; g++) begin : g_dec
    trit_decoder u_dec (.code_i(codes[g]), .oh_o(ohs[g]), .bad_o(bads[g]));
    always_comb begin
      if (ohs[g][1])      vals[g] = 4'sd1;
      else if (ohs[g][2]) vals[g] = bal_i ? -4'sd1 : 4'sd2;
      else                vals[g] = 4'sd0;
    end
  end

  dsum_t total, dig_v, car_v;
  trit_oh_t dig_oh, car_oh;

  always_comb begin
    total = vals[0] + vals[1] + vals[2];
    dig_v = total;
    car_v = 4'sd0;
    if (!bal_i) begin
      if (total >= 4'sd6) begin
        dig_v = total - 4'sd6;
        car_v = 4'sd2;
      end else if (total >= 4'sd3) begin
        dig_v = total - 4'sd3;
        car_v = 4'sd1;
      end
    end else begin
      if (total >= 4'sd2) begin
        dig_v = total - 4'sd3;
        car_v = 4'sd1;
      end else if (total <= -4'sd2) begin
        dig_v = total + 4'sd3;
        car_v = -4'sd1;
      end
    end
    dig_oh = val_to_oh(dig_v);
    car_oh = val_to_oh(car_v);
  end

  trit_encoder u_enc_s (.oh_i(dig_oh), .code_o(s_o));
  trit_encoder u_enc_c (.oh_i(car_oh), .code_o(c_o));

  assign err_o = |bads;
endmodule

// File: rtl/ternary_rc_adder.sv
module ternary_rc_adder
  import tadd_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic           bal_mode,
  input  logic           negate_b,
  input  logic [2*N-1:0] op_a,
  input  logic [2*N-1:0] op_b,
  input  logic [1:0]     carry_in,
  output logic [2*N-1:0] sum,
  output logic [1:0]     carry_out,
  output logic           code_err
);
  localparam int unsigned W = 2 * N;

  trit_code_t     chain [N+1];
  logic [N-1:0]   errs;
  logic           flip;

  assign flip     = bal_mode & negate_b;
  assign chain[0] = carry_in;

  for (genvar i = 0; i < N; i++) begin : g_dig
    trit_code_t a_d, b_d, b_eff, s_d;
    assign a_d   = op_a[2*i +: 2];
    assign b_d   = op_b[2*i +: 2];
    // swapping the two bits exchanges 01 and 10, keeps 00 and 11
    assign b_eff = flip ? {b_d[0], b_d[1]} : b_d;

    trit_digit_cell u_cell (
      .bal_i (bal_mode),
      .a_i   (a_d),
      .b_i   (b_eff),
      .c_i   (chain[i]),
      .s_o   (s_d),
      .c_o   (chain[i+1]),
      .err_o (errs[i])
    );
    assign sum[2*i +: 2] = s_d;
  end

  assign carry_out = chain[N];
  assign code_err  = |errs;

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/tadd_checker.sv
module tadd_checker #(
  parameter int unsigned N = 4
) (
  input logic           bal_mode,
  input logic           negate_b,
  input logic [2*N-1:0] op_a,
  input logic [2*N-1:0] op_b,
  input logic [1:0]     carry_in,
  input logic [2*N-1:0] sum,
  input logic [1:0]     carry_out,
  input logic           code_err
);
  function automatic int dval(input logic [1:0] c, input logic bal, input logic neg);
    int v;
    case (c)
      2'b01:   v = 1;
      2'b10:   v = bal ? -1 : 2;
      default: v = 0;
    endcase
    if (bal && neg) v = -v;
    return v;
  endfunction

  function automatic int wval(input logic [2*N-1:0] w, input logic bal, input logic neg);
    int acc, p;
    acc = 0;
    p = 1;
    for (int i = 0; i < N; i++) begin
      acc += p * dval(w[2*i +: 2], bal, neg);
      p *= 3;
    end
    return acc;
  endfunction

  function automatic logic any_bad(input logic [2*N-1:0] w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++) r |= (w[2*i +: 2] == 2'b11);
    return r;
  endfunction

  function automatic int pw3();
    int p;
    p = 1;
    for (int i = 0; i < N; i++) p *= 3;
    return p;
  endfunction

  logic in_bad, out_bad;
  int   lhs, rhs;

  always_comb begin
    in_bad  = any_bad(op_a) | any_bad(op_b) | (carry_in == 2'b11);
    out_bad = any_bad(sum) | (carry_out == 2'b11);
    lhs     = wval(op_a, bal_mode, 1'b0) + wval(op_b, bal_mode, negate_b)
              + dval(carry_in, bal_mode, 1'b0);
    rhs     = wval(sum, bal_mode, 1'b0) + pw3() * dval(carry_out, bal_mode, 1'b0);

    AST_ERR_FLAG: assert (code_err == in_bad) else $error("err flag mismatch"); // R9
    AST_LEGAL_OUT: assert (in_bad || !out_bad) else $error("illegal output code"); // R10
    AST_UNB_CARRY: assert (bal_mode || in_bad || carry_in == 2'b10 || carry_out != 2'b10)
      else $error("unsigned carry 2"); // R4
    AST_UNB_SUM: assert (bal_mode || in_bad || lhs == rhs) else $error("unsigned sum"); // R3
    AST_BAL_SUM: assert (!bal_mode || in_bad || lhs == rhs) else $error("balanced sum"); // R6
  end
endmodule

bind ternary_rc_adder tadd_checker #(.N(N)) u_tadd_checker (
  .bal_mode  (bal_mode),
  .negate_b  (negate_b),
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .code_err  (code_err)
);

// File: tb/ternary_rc_adder_bench.sv
module ternary_rc_adder_bench;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2 * N;

  logic clk;
  logic bal_mode, negate_b;
  logic [W-1:0] op_a, op_b, sum;
  logic [1:0] carry_in, carry_out;
  logic code_err;

  int checks = 0;
  int fails = 0;
  int P3;

  ternary_rc_adder #(.N(N)) u_ternary_rc_adder (
    .bal_mode(bal_mode), .negate_b(negate_b), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum(sum), .carry_out(carry_out), .code_err(code_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cu(input int d);
    return (d == 2) ? 2'b10 : (d == 1) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] cb(input int d);
    return (d == -1) ? 2'b10 : (d == 1) ? 2'b01 : 2'b00;
  endfunction

  // unsigned digits of v, N+1 digits (top one is the carry)
  function automatic logic [W+1:0] enc_u(input int v);
    logic [W+1:0] r;
    for (int i = 0; i <= N; i++) begin
      r[2*i +: 2] = cu(v % 3);
      v = v / 3;
    end
    return r;
  endfunction

  function automatic logic [W+1:0] enc_b(input int v);
    logic [W+1:0] r;
    for (int i = 0; i <= N; i++) begin
      int m;
      m = ((v % 3) + 3) % 3;
      if (m == 2) begin
        r[2*i +: 2] = 2'b10;
        v = (v + 1) / 3;
      end else begin
        r[2*i +: 2] = cb(m);
        v = (v - m) / 3;
      end
    end
    return r;
  endfunction

  task automatic apply(input logic bm, input logic nb, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [1:0] c);
    @(negedge clk);
    bal_mode = bm; negate_b = nb; op_a = a; op_b = b; carry_in = c;
    #(CLK_PERIOD/4);
  endtask

  task automatic t_zero();
    apply(1'b0, 1'b0, '0, '0, 2'b00);
    chk("R12 sum", sum, 0);
    chk("R12 carry", carry_out, 0);
    chk("R12 err", code_err, 0);
    apply(1'b1, 1'b0, '0, '0, 2'b00);
    chk("R12 bal sum", {carry_out, sum}, 0);
  endtask

  task automatic t_cell_unsigned();
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          logic [W-1:0] av, bv;
          av = '0; bv = '0;
          av[1:0] = cu(a); bv[1:0] = cu(b);
          apply(1'b0, 1'b0, av, bv, cu(c));
          chk("R2 digit", sum[1:0], cu((a + b + c) % 3));
          chk("R2 carry", sum[3:2], cu((a + b + c) / 3));
          chk("R1 err", code_err, 0);
        end
  endtask

  task automatic t_cell_balanced();
    int nz;
    nz = 0;
    for (int a = -1; a <= 1; a++)
      for (int b = -1; b <= 1; b++)
        for (int c = -1; c <= 1; c++) begin
          logic [W-1:0] av, bv;
          logic [W+1:0] e;
          av = '0; bv = '0;
          av[1:0] = cb(a); bv[1:0] = cb(b);
          apply(1'b1, 1'b0, av, bv, cb(c));
          e = enc_b(a + b + c);
          chk("R5 digit", sum[1:0], e[1:0]);
          chk("R5 carry", sum[3:2], e[3:2]);
          if (c == 0 && sum[3:2] != 2'b00) nz++;
          if (c == 0)
            chk("R11 pair", sum[3:2] != 2'b00, (a == b) && (a != 0));
        end
    chk("R11 count", nz, 2);
  endtask

  task automatic t_ripple_unsigned();
    int s;
    s = 7;
    for (int k = 0; k < 150; k++) begin
      int a, b, c;
      logic [W+1:0] e, ea, eb;
      s = (s * 1103 + 12345) % 65521;
      a = s % P3;
      s = (s * 1103 + 12345) % 65521;
      b = s % P3;
      c = k % 2;
      ea = enc_u(a); eb = enc_u(b); e = enc_u(a + b + c);
      apply(1'b0, 1'b0, ea[W-1:0], eb[W-1:0], cu(c));
      chk("R3 value", {carry_out, sum}, e);
      chk("R4 carry", carry_out != 2'b10, 1);
    end
    apply(1'b0, 1'b0, enc_u(P3 - 1), enc_u(P3 - 1), 2'b01);
    chk("R3 max", {carry_out, sum}, enc_u(2 * P3 - 1));
    chk("R4 max carry", carry_out, 2'b01);
  endtask

  task automatic t_ripple_balanced();
    int s, m;
    m = (P3 - 1) / 2;
    s = 99;
    for (int k = 0; k < 150; k++) begin
      int a, b, c;
      logic [W+1:0] ea, eb;
      s = (s * 1103 + 12345) % 65521;
      a = (s % P3) - m;
      s = (s * 1103 + 12345) % 65521;
      b = (s % P3) - m;
      c = (k % 3) - 1;
      ea = enc_b(a); eb = enc_b(b);
      apply(1'b1, 1'b0, ea[W-1:0], eb[W-1:0], cb(c));
      chk("R6 value", {carry_out, sum}, enc_b(a + b + c));
    end
    apply(1'b1, 1'b0, enc_b(m), enc_b(m), 2'b01);
    chk("R6 top", {carry_out, sum}, enc_b(2 * m + 1));
    apply(1'b1, 1'b0, enc_b(-m), enc_b(-m), 2'b10);
    chk("R6 bottom", {carry_out, sum}, enc_b(-2 * m - 1));
  endtask

  task automatic t_negate();
    logic [W+1:0] ea, eb;
    ea = enc_b(0); eb = enc_b(23);
    apply(1'b1, 1'b1, ea[W-1:0], eb[W-1:0], 2'b00);
    chk("R7 neg", {carry_out, sum}, enc_b(-23));
    ea = enc_b(-17); eb = enc_b(-30);
    apply(1'b1, 1'b1, ea[W-1:0], eb[W-1:0], 2'b01);
    chk("R7 sub", {carry_out, sum}, enc_b(-17 + 30 + 1));
    ea = enc_u(40); eb = enc_u(25);
    apply(1'b0, 1'b1, ea[W-1:0], eb[W-1:0], 2'b00);
    chk("R8 ignored", {carry_out, sum}, enc_u(65));
  endtask

  task automatic t_illegal();
    logic [W+1:0] ea, eb;
    logic [W-1:0] av;
    ea = enc_u(5); eb = enc_u(7);
    av = ea[W-1:0];
    av[5:4] = 2'b11;
    apply(1'b0, 1'b0, av, eb[W-1:0], 2'b00);
    chk("R9 err a", code_err, 1);
    chk("R9 as zero", {carry_out, sum}, enc_u(12));
    apply(1'b1, 1'b0, '0, '0, 2'b11);
    chk("R9 err cin", code_err, 1);
    chk("R9 cin zero", {carry_out, sum}, 0);
    apply(1'b1, 1'b0, {W{1'b0}}, {2'b11, {(W-2){1'b0}}}, 2'b01);
    chk("R9 err b", code_err, 1);
    chk("R10 legal out", {carry_out, sum}, enc_b(1));
  endtask

  initial begin
    P3 = 1;
    for (int i = 0; i < N; i++) P3 *= 3;
    bal_mode = 0; negate_b = 0; op_a = '0; op_b = '0; carry_in = '0;
    t_zero();
    t_cell_unsigned();
    t_cell_balanced();
    t_ripple_unsigned();
    t_ripple_balanced();
    t_negate();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule